// File: doc/BRIEF.md
# PCI Configuration Access Decoder

This block sits on the host-side I/O bus of a host bridge and implements PCI configuration mechanism #1. It has two I/O ports. A 32-bit address latch at port 0CF8h selects a target: an enable flag, a bus, a device, a function and a dword register number. A data window at port 0CFCh then reads or writes the selected register. The block claims only these two ports. Every other I/O cycle, and every data-window cycle that the latch does not aim at bus 0 with the enable flag set, goes downstream unchanged. Each such cycle is marked with a one-cycle forward strobe.

Behind the window sit three configuration functions. The first is the host bridge, at device 0 function 0. It holds an identity word, a command/status word and a control word. The second is a memory-tuning function at device 0 function 1. It stays hidden until a control bit in the host bridge turns it on. The third is a graphics-port bridge at device 1 function 0. A memory ECC error pulse latches a status flag, and software clears that flag by writing a one to it. An active-low system-error output follows the flag only while software has enabled it. The bus-parity status bit is tied to zero. A claimed read returns its data one cycle after the strobe, with a valid flag. A response state machine with two states, ST_IDLE and ST_RESP, produces it. On a claimed read the machine goes from ST_IDLE to ST_RESP. It stays in ST_RESP while claimed reads keep arriving. It returns to ST_IDLE in the first cycle that has no claimed read.

Top module: `cfg_access_decoder`

## Requirements
- R1: A write to I/O port 0CF8h loads the address latch through the byte enables. Only bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (dword) are kept, and all other bits read as zero. Writing FFFFFFFFh therefore reads back as 80FFFFFCh. A claimed read drives rd_valid high, with the data, exactly one cycle after its strobe cycle.
- R2: An I/O cycle to any port other than 0CF8h and 0CFCh raises fwd_strobe in its strobe cycle and produces no rd_valid.
- R3: A data-window cycle is forwarded in the same way when the latch has bit 31 clear or a nonzero bus number.
- R4: The host-bridge control word at offset 4Ch is writable through the byte enables. Its bit 0 enables device 0 function 1.
- R5: While function 1 is disabled, every read of it returns FFh in the addressed lanes and its writes are ignored.
- R6: While function 1 is enabled, its offsets 00h-3Fh read as all ones, and its tuning word at offset 40h reads back what was written.
- R7: A read of a register that does not exist returns FFh in each addressed byte lane. This covers any device above 1, any function other than 0 and 1, and any unlisted offset.
- R8: Offset 00h of the host bridge reads the parameter HOST_ID (default 0C111AB5h). Offset 00h of the graphics bridge reads GFX_ID (default 0C121AB5h).
- R9: An ecc_err pulse sets bit 30 of host-bridge offset 04h. Writing 04h with byte lane 3 enabled and data bit 30 set clears it. If a pulse and a clear fall in the same cycle, the pulse wins.
- R10: serr_n is low exactly while the ECC flag is set and command bit 8 of offset 04h is set.
- R11: Bit 31 of host-bridge offset 04h always reads 0, even after a write of one.
- R12: After reset, the address latch, the control word, the tuning word, the command bit and the ECC flag are all zero, rd_valid is low and serr_n is high.
- R13: Byte enables qualify both directions. Writes change only enabled lanes, and read data is zero in lanes that are not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_strobe | input | 1 | One-cycle I/O cycle request |
| io_write | input | 1 | 1 = write cycle, 0 = read cycle |
| io_addr | input | IO_ADDR_W | I/O port address |
| io_be | input | DATA_W/8 | Byte-lane enables |
| io_wdata | input | DATA_W | Write data |
| ecc_err | input | 1 | Memory ECC error pulse |
| fwd_strobe | output | 1 | Cycle not claimed, pass it downstream |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data, lanes masked by the byte enables |
| serr_n | output | 1 | Active-low system error |

## Verification
A wrong latch state shows up in the first data-window cycle that follows. That cycle is either wrongly forwarded or answered from the wrong function, and the rd_valid word one cycle later shows which. A stuck enable or a stuck ECC flag shows up only when the control word or offset 04h is read back, or in the level of serr_n one cycle after the write that should have changed it. For this reason the bench reads back every register after each write that touches it. Each read is checked against an expected word queued by the driver, in the cycle in which that word is due.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

    typedef struct packed {
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] dword;
    } cfg_sel_t;

    localparam logic [31:0] LATCH_KEEP = 32'h80FF_FFFC;
    localparam logic [7:0]  OFS_ID     = 8'h00;
    localparam logic [7:0]  OFS_CMDSTS = 8'h04;
    localparam logic [7:0]  OFS_CTRL   = 8'h4C;
    localparam logic [7:0]  OFS_TUNE   = 8'h40;
    localparam logic [7:0]  HDR_LIMIT  = 8'h40;
endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] latch_q
);
    import cfg_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_en) begin
            latch_q <= ((latch_q & ~lane_mask) | (wdata & lane_mask)) & LATCH_KEEP;
        end
    end
endmodule

// File: rtl/cfg_func_regs.sv
module cfg_func_regs #(
    parameter int          DATA_W  = 32,
    parameter logic [31:0] HOST_ID = 32'h0C11_1AB5,
    parameter logic [31:0] GFX_ID  = 32'h0C12_1AB5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_pkg::cfg_sel_t sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ecc_err,
    output logic [DATA_W-1:0] rdata,
    output logic              serr_en,
    output logic              ecc_flag
);
    import cfg_pkg::*;

    localparam logic [DATA_W-1:0] ONES = '1;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] tune_q;
    logic [7:0]        ofs;
    logic              is_host, is_tune, is_gfx;

    assign ofs     = {sel.dword, 2'b00};
    assign is_host = (sel.dev == 5'd0) && (sel.fn == 3'd0);
    assign is_tune = (sel.dev == 5'd0) && (sel.fn == 3'd1) && ctrl_q[0];
    assign is_gfx  = (sel.dev == 5'd1) && (sel.fn == 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            tune_q   <= '0;
            serr_en  <= 1'b0;
            ecc_flag <= 1'b0;
        end else begin
            if (wr_en && is_host && ofs == OFS_CTRL)
                ctrl_q <= (ctrl_q & ~lane_mask) | (wdata & lane_mask);
            if (wr_en && is_tune && ofs == OFS_TUNE)
                tune_q <= (tune_q & ~lane_mask) | (wdata & lane_mask);
            if (wr_en && is_host && ofs == OFS_CMDSTS && lane_mask[8])
                serr_en <= wdata[8];
            if (ecc_err)
                ecc_flag <= 1'b1;
            else if (wr_en && is_host && ofs == OFS_CMDSTS && lane_mask[30] && wdata[30])
                ecc_flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = ONES;
        if (is_host) begin
            unique case (ofs)
                OFS_ID:     rdata = HOST_ID;
                OFS_CMDSTS: rdata = {1'b0, ecc_flag, 21'd0, serr_en, 8'd0};
                OFS_CTRL:   rdata = ctrl_q;
                default:    rdata = ONES;
            endcase
        end else if (is_tune) begin
            if (ofs == OFS_TUNE) rdata = tune_q;
            else                 rdata = ONES;
        end else if (is_gfx) begin
            if (ofs == OFS_ID) rdata = GFX_ID;
            else               rdata = ONES;
        end
    end
endmodule

// File: rtl/cfg_resp_fsm.sv
module cfg_resp_fsm #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    import cfg_pkg::*;

    resp_state_e       state_q, state_d;
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) word_q <= rd_word;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req)  state_d = ST_RESP;
            ST_RESP: if (!rd_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_valid = (state_q == ST_RESP);
        rd_data  = rd_valid ? word_q : '0;
    end
endmodule

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder #(
    parameter int                    IO_ADDR_W = 16,
    parameter int                    DATA_W    = 32,
    parameter logic [IO_ADDR_W-1:0]  ADDR_PORT = 16'h0CF8,
    parameter logic [IO_ADDR_W-1:0]  DATA_PORT = 16'h0CFC,
    parameter logic [31:0]           HOST_ID   = 32'h0C11_1AB5,
    parameter logic [31:0]           GFX_ID    = 32'h0C12_1AB5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_strobe,
    input  logic                 io_write,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic [DATA_W/8-1:0]  io_be,
    input  logic [DATA_W-1:0]    io_wdata,
    input  logic                 ecc_err,
    output logic                 fwd_strobe,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 serr_n
);
    import cfg_pkg::*;

    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] latch_q;
    logic [DATA_W-1:0] func_rdata;
    logic [DATA_W-1:0] rd_word;
    logic              hit_latch, hit_window, claimed;
    logic              serr_en, ecc_flag;
    cfg_sel_t          sel;

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = {8{io_be[i]}};
    end

    assign hit_latch  = (io_addr == ADDR_PORT);
    assign hit_window = (io_addr == DATA_PORT) && latch_q[31] && (latch_q[30:16] == '0);
    assign claimed    = hit_latch || hit_window;
    assign fwd_strobe = io_strobe && !claimed;

    assign sel.dev   = latch_q[15:11];
    assign sel.fn    = latch_q[10:8];
    assign sel.dword = latch_q[7:2];

    assign rd_word = (hit_latch ? latch_q : func_rdata) & lane_mask;
    assign serr_n  = !(serr_en && ecc_flag);

    cfg_addr_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (io_strobe && io_write && hit_latch),
        .lane_mask (lane_mask),
        .wdata     (io_wdata),
        .latch_q   (latch_q)
    );

    cfg_func_regs #(.DATA_W(DATA_W), .HOST_ID(HOST_ID), .GFX_ID(GFX_ID)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_en     (io_strobe && io_write && hit_window),
        .lane_mask (lane_mask),
        .wdata     (io_wdata),
        .ecc_err   (ecc_err),
        .rdata     (func_rdata),
        .serr_en   (serr_en),
        .ecc_flag  (ecc_flag)
    );

    cfg_resp_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (io_strobe && !io_write && claimed),
        .rd_word  (rd_word),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/cfg_access_decoder_chk.sv
module cfg_access_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic io_strobe,
    input logic io_write,
    input logic fwd_strobe,
    input logic rd_valid,
    input logic serr_n,
    input logic ecc_err,
    input logic ecc_flag
);
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (io_strobe && !io_write && !fwd_strobe) |=> rd_valid); // R1
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(io_strobe && !io_write && !fwd_strobe)); // R1
    AST_FWD_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_strobe |=> !rd_valid); // R2
    AST_FWD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_strobe |-> io_strobe); // R2
    AST_ECC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_err |=> ecc_flag); // R9
    AST_SERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!serr_n && !(io_strobe && io_write)) |=> !serr_n); // R10
endmodule

bind cfg_access_decoder cfg_access_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_strobe  (io_strobe),
    .io_write   (io_write),
    .fwd_strobe (fwd_strobe),
    .rd_valid   (rd_valid),
    .serr_n     (serr_n),
    .ecc_err    (ecc_err),
    .ecc_flag   (ecc_flag)
);

// File: tb/cfg_access_decoder_test.sv
`timescale 1ns/1ps
module cfg_access_decoder_test;
    localparam logic [31:0] HOST_ID = 32'h0C11_1AB5;
    localparam logic [31:0] GFX_ID  = 32'h0C12_1AB5;
    localparam logic [15:0] P_ADDR  = 16'h0CF8;
    localparam logic [15:0] P_DATA  = 16'h0CFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_strobe = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        ecc_err = 1'b0;
    logic        fwd_strobe, rd_valid, serr_n;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    cfg_access_decoder uut (
        .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_write(io_write),
        .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata), .ecc_err(ecc_err),
        .fwd_strobe(fwd_strobe), .rd_valid(rd_valid), .rd_data(rd_data), .serr_n(serr_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cfga(input int dev, input int fn, input int ofs);
        return 32'h8000_0000 | (32'(dev) << 11) | (32'(fn) << 8) | 32'(ofs);
    endfunction

    task automatic drive(input bit wr, input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        io_strobe = 1'b1; io_write = wr; io_addr = a; io_be = be; io_wdata = d;
    endtask

    task automatic release_bus();
        @(negedge clk);
        io_strobe = 1'b0; io_write = 1'b0;
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        drive(1'b1, a, be, d);
        release_bus();
    endtask

    task automatic do_rd(input logic [15:0] a, input logic [3:0] be, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        drive(1'b0, a, be, 32'h0);
        release_bus();
    endtask

    task automatic do_fwd(input bit wr, input logic [15:0] a, input string tag);
        drive(wr, a, 4'hF, 32'h1234_5678);
        #1;
        check(fwd_strobe === 1'b1, tag, {31'd0, fwd_strobe}, 32'd1);
        release_bus();
    endtask

    task automatic set_latch(input logic [31:0] v);
        do_wr(P_ADDR, 4'hF, v);
    endtask

    // Scoreboard monitor: pops one expected word for every rd_valid cycle
    always @(negedge clk) begin
        if (rst_n && !finished && rd_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected rd_valid", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid === 1'b0, "R12 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(serr_n === 1'b1, "R12 serr_n after reset", {31'd0, serr_n}, 32'd1);
        do_rd(P_ADDR, 4'hF, 32'h0, "R12 latch reset value");

        // R1 latch layout
        set_latch(32'hFFFF_FFFF);
        do_rd(P_ADDR, 4'hF, 32'h80FF_FFFC, "R1 latch kept bits");

        // R2 other ports forwarded
        do_fwd(1'b0, 16'h0080, "R2 forward read");
        do_fwd(1'b1, 16'h03F8, "R2 forward write");
        do_fwd(1'b0, 16'h0CF9, "R2 forward near port");

        // R3 window forwarded when disabled or off bus 0
        set_latch(32'h0000_0000);
        do_fwd(1'b0, P_DATA, "R3 enable clear");
        set_latch(32'h8001_0000);
        do_fwd(1'b0, P_DATA, "R3 bus nonzero");

        // R8 identity words, R13 lane mask
        set_latch(cfga(0, 0, 'h00));
        do_rd(P_DATA, 4'hF, HOST_ID, "R8 host id");
        do_rd(P_DATA, 4'b0011, HOST_ID & 32'h0000_FFFF, "R13 read lane mask");
        set_latch(cfga(1, 0, 'h00));
        do_rd(P_DATA, 4'hF, GFX_ID, "R8 gfx id");

        // R5 function 1 disabled
        set_latch(cfga(0, 1, 'h40));
        do_rd(P_DATA, 4'hF, 32'hFFFF_FFFF, "R5 disabled tune read");
        do_wr(P_DATA, 4'hF, 32'h1234_5678);
        set_latch(cfga(0, 1, 'h08));
        do_rd(P_DATA, 4'b1100, 32'hFFFF_0000, "R5 disabled header lanes");

        // R4 control word
        set_latch(cfga(0, 0, 'h4C));
        do_rd(P_DATA, 4'hF, 32'h0, "R12 control reset");
        do_wr(P_DATA, 4'b0001, 32'hAAAA_AA01);
        do_rd(P_DATA, 4'hF, 32'h0000_0001, "R4 control lane write");

        // R6 function 1 enabled
        set_latch(cfga(0, 1, 'h40));
        do_rd(P_DATA, 4'hF, 32'h0, "R5 write while disabled ignored");
        do_wr(P_DATA, 4'hF, 32'hCAFE_F00D);
        do_rd(P_DATA, 4'hF, 32'hCAFE_F00D, "R6 tune readback");
        do_wr(P_DATA, 4'b0100, 32'h0055_0000);
        do_rd(P_DATA, 4'hF, 32'hCA55_F00D, "R13 single lane write");
        set_latch(cfga(0, 1, 'h10));
        do_rd(P_DATA, 4'hF, 32'hFFFF_FFFF, "R6 header all ones");

        // R7 nonexistent
        set_latch(cfga(2, 0, 'h00));
        do_rd(P_DATA, 4'b0110, 32'h00FF_FF00, "R7 device 2 lanes");
        set_latch(cfga(0, 0, 'h80));
        do_rd(P_DATA, 4'hF, 32'hFFFF_FFFF, "R7 unlisted offset");
        set_latch(cfga(0, 2, 'h00));
        do_rd(P_DATA, 4'hF, 32'hFFFF_FFFF, "R7 function 2");

        // R4 disable function 1 again
        set_latch(cfga(0, 0, 'h4C));
        do_wr(P_DATA, 4'b0001, 32'h0);
        set_latch(cfga(0, 1, 'h40));
        do_rd(P_DATA, 4'hF, 32'hFFFF_FFFF, "R4 function 1 hidden again");

        // R9 R10 R11 ECC and system error
        set_latch(cfga(0, 0, 'h04));
        do_rd(P_DATA, 4'hF, 32'h0, "R12 command/status reset");
        ecc_err = 1'b1;
        @(negedge clk);
        ecc_err = 1'b0;
        check(serr_n === 1'b1, "R10 no serr while disabled", {31'd0, serr_n}, 32'd1);
        do_rd(P_DATA, 4'hF, 32'h4000_0000, "R9 ecc flag set");
        do_wr(P_DATA, 4'b0010, 32'h0000_0100);
        check(serr_n === 1'b0, "R10 serr asserted", {31'd0, serr_n}, 32'd0);
        do_rd(P_DATA, 4'hF, 32'h4000_0100, "R9 flag and enable");
        do_wr(P_DATA, 4'b0111, 32'h4000_0100);
        do_rd(P_DATA, 4'hF, 32'h4000_0100, "R9 clear needs lane 3");
        do_wr(P_DATA, 4'b1000, 32'hC000_0000);
        check(serr_n === 1'b1, "R10 serr released", {31'd0, serr_n}, 32'd1);
        do_rd(P_DATA, 4'hF, 32'h0000_0100, "R11 parity bit zero after clear");
        do_wr(P_DATA, 4'hF, 32'h8000_0100);
        do_rd(P_DATA, 4'hF, 32'h0000_0100, "R11 parity bit write of one");
        // set wins over clear in the same cycle
        ecc_err = 1'b1;
        do_wr(P_DATA, 4'b1000, 32'h4000_0000);
        ecc_err = 1'b0;
        do_rd(P_DATA, 4'hF, 32'h4000_0100, "R9 pulse beats clear");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 missing responses", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule